// File: doc/BRIEF.md
# Connector Digital Port Controller

This block is a slave register file on an 8-bit I/O bus and occupies a fixed window of 32 byte addresses. It serves a row of identical 50-pin digital connectors. Each connector has an output latch for its odd pins 1-15 and a second output latch for its even pins 2-16. It also has two read-only ports that sample the odd pins 17-31 and 33-47. A ground-control register can force any group of four even pins to a driven-low ground, whatever the even latch holds. Read-only status registers report jumper banks, the pin 50 level of each connector and two supply power-good flags.

The bus side takes a 5-bit offset that has already been decoded into the window, a read strobe, a write strobe and write data. A write is taken on the rising clock edge while the write strobe is high. Read data is combinational from the registered state while the read strobe is high, and zero otherwise. Address and control pins are plain levels with no handshake, because every access completes in one cycle. Offsets 0x0C to 0x17 belong to other functions that are not built here, and they read as zero.

Top module: `dio_port_ctrl`

## Requirements
- R1: A low `rst_n` clears every output latch and the ground-control register. While reset is held, `odd_out` and `even_out` are zero and reads of the latch offsets return 0.
- R2: A write to offset 4k+0 (connector k, k = 0..2) loads the odd latch. `odd_out[8k+7:8k]` shows the value from the next cycle on, with bit 0 driving pin 1 and bit 7 driving pin 15. A read of that offset returns the latch.
- R3: Offset 4k+1 returns `conn_in[16k+7:16k]` (pins 17-31 odd) and offset 4k+2 returns `conn_in[16k+15:16k+8]` (pins 33-47 odd), with the lowest pin number in bit 0. The value is sampled in the same cycle as the read.
- R4: A write to offset 4k+3 loads the even latch. Bit 0 is pin 2 and bit 7 is pin 16. It drives `even_out[8k+7:8k]` from the next cycle on, and a read of that offset returns the latch.
- R5: Offset 0x1B is the ground-control register. Bit 2k covers connector k pins 2-8, which are even-latch bits 3:0. Bit 2k+1 covers connector k pins 10-16, which are bits 7:4. Bits 7:6 read 0.
- R6: While a ground bit is 1, its four `even_out` pins are 0 and their `even_oe` bits are 1, whatever the latch holds. The latch keeps its value, still accepts writes and still reads back. Clearing the bit drives the current latch value onto the pins again.
- R7: Offsets 0x18 and 0x19 return the 8-bit jumper inputs `jmp_a` and `jmp_b`. Offset 0x1A returns the 4-bit `jmp_c` in bits 3:0, with the upper bits at 0. An installed jumper reads 0 and an absent jumper reads 1.
- R8: Offset 0x1C returns the pin 50 level of connector k in bit k. Offset 0x1D returns the 3.3 V power-good in bit 0 and the 2.5 V power-good in bit 1, where 1 means good. All other bits read 0.
- R9: Offsets 0x0C-0x17, 0x1E and 0x1F read 0. A write to any read-only or reserved offset changes no latch and no output.
- R10: `bus_rdata` is 0 whenever `bus_rd` is low.
- R11: `odd_oe` and `even_oe` are 0 while reset is held and all 1 from the first clock edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 5 | Byte offset inside the window |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, zero when not reading |
| conn_in | input | 48 | Odd input pins 17-47, 16 per connector |
| jmp_a | input | 8 | First jumper bank, 0 = installed |
| jmp_b | input | 8 | Second jumper bank, 0 = installed |
| jmp_c | input | 4 | Third jumper bank, 0 = installed |
| pin50_in | input | 3 | Pin 50 level per connector |
| pgood_in | input | 2 | Bit 0: 3.3 V good, bit 1: 2.5 V good |
| odd_out | output | 24 | Odd pins 1-15, 8 per connector |
| odd_oe | output | 24 | Output enables for odd pins |
| even_out | output | 24 | Even pins 2-16 after ground override |
| even_oe | output | 24 | Output enables for even pins |

## Verification
Two functions can meet in the same cycle on one even group: a write to an even latch whose group is grounded, and the ground override acting on the pins. The bench provokes this by setting a ground bit, writing a new even value into that connector, and then clearing the bit. It judges the result by reading the latch back and watching the pins. While the group is grounded, the pins of that group show 0 and the readback shows the new value. After the bit is cleared, the new value appears on the pins. A neighbouring group that is not grounded shows the new value the whole time.

// File: rtl/dio_pkg.sv
package dio_pkg;
  localparam int DW     = 8;
  localparam int AW     = 5;
  localparam int NCONN  = 3;
  localparam int IN_PER = 2 * DW;
  localparam int JC_W   = 4;
  localparam int PG_W   = 2;

  typedef enum logic [1:0] {
    SUB_ODD_OUT = 2'd0,
    SUB_IN_LO   = 2'd1,
    SUB_IN_HI   = 2'd2,
    SUB_EVEN    = 2'd3
  } sub_off_e;

  localparam logic [AW-1:0] OFF_JMP_A = 5'h18;
  localparam logic [AW-1:0] OFF_JMP_B = 5'h19;
  localparam logic [AW-1:0] OFF_JMP_C = 5'h1A;
  localparam logic [AW-1:0] OFF_GND   = 5'h1B;
  localparam logic [AW-1:0] OFF_PIN50 = 5'h1C;
  localparam logic [AW-1:0] OFF_PGOOD = 5'h1D;
endpackage

// File: rtl/dio_conn_port.sv
module dio_conn_port
  import dio_pkg::*;
#(
  parameter int W   = 8,
  parameter int IDX = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          rd_en,
  input  logic          wr_en,
  input  logic [W-1:0]  wdata,
  input  logic [W-1:0]  in_lo,
  input  logic [W-1:0]  in_hi,
  input  logic [1:0]    gnd,
  output logic [W-1:0]  odd_q,
  output logic [W-1:0]  even_pin,
  output logic [W-1:0]  rdata
);
  localparam int GW = W / 2;
  localparam logic [AW-3:0] MY_SLOT = (AW-2)'(IDX);

  logic       hit;
  sub_off_e   sub;
  logic [W-1:0] even_q;

  assign hit = (addr[AW-1:2] == MY_SLOT);
  assign sub = sub_off_e'(addr[1:0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      odd_q  <= '0;
      even_q <= '0;
    end else if (wr_en && hit) begin
      if (sub == SUB_ODD_OUT) odd_q  <= wdata;
      if (sub == SUB_EVEN)    even_q <= wdata;
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_grp
    assign even_pin[g*GW +: GW] = gnd[g] ? '0 : even_q[g*GW +: GW];
  end

  always_comb begin
    rdata = '0;
    if (rd_en && hit) begin
      unique case (sub)
        SUB_ODD_OUT: rdata = odd_q;
        SUB_IN_LO:   rdata = in_lo;
        SUB_IN_HI:   rdata = in_hi;
        SUB_EVEN:    rdata = even_q;
      endcase
    end
  end

  // R2
  odd_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hit && sub == SUB_ODD_OUT) |=> (odd_q == $past(wdata)));

  // R4
  even_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hit && sub == SUB_EVEN && gnd == 2'b00) |=>
      (gnd != 2'b00 || even_pin == $past(wdata)));
endmodule

// File: rtl/dio_ctrl_regs.sv
module dio_ctrl_regs
  import dio_pkg::*;
#(
  parameter int NGRP = 6,
  parameter int NP50 = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   addr,
  input  logic            rd_en,
  input  logic            wr_en,
  input  logic [DW-1:0]   wdata,
  input  logic [DW-1:0]   jmp_a,
  input  logic [DW-1:0]   jmp_b,
  input  logic [JC_W-1:0] jmp_c,
  input  logic [NP50-1:0] pin50,
  input  logic [PG_W-1:0] pgood,
  output logic [NGRP-1:0] gnd_q,
  output logic [DW-1:0]   rdata
);
  always_ff @(posedge clk) begin
    if (!rst_n)                          gnd_q <= '0;
    else if (wr_en && addr == OFF_GND)   gnd_q <= wdata[NGRP-1:0];
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (addr)
        OFF_JMP_A: rdata = jmp_a;
        OFF_JMP_B: rdata = jmp_b;
        OFF_JMP_C: rdata = DW'(jmp_c);
        OFF_GND:   rdata = DW'(gnd_q);
        OFF_PIN50: rdata = DW'(pin50);
        OFF_PGOOD: rdata = DW'(pgood);
        default:   rdata = '0;
      endcase
    end
  end

  // R9
  gnd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr != OFF_GND) |=> $stable(gnd_q));

  // R5
  gnd_top_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == OFF_GND) |-> (rdata[DW-1:NGRP] == '0));
endmodule

// File: rtl/dio_port_ctrl.sv
module dio_port_ctrl
  import dio_pkg::*;
#(
  parameter int N_CONN = NCONN
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [AW-1:0]          bus_addr,
  input  logic                   bus_rd,
  input  logic                   bus_wr,
  input  logic [DW-1:0]          bus_wdata,
  output logic [DW-1:0]          bus_rdata,
  input  logic [N_CONN*IN_PER-1:0] conn_in,
  input  logic [DW-1:0]          jmp_a,
  input  logic [DW-1:0]          jmp_b,
  input  logic [JC_W-1:0]        jmp_c,
  input  logic [N_CONN-1:0]      pin50_in,
  input  logic [PG_W-1:0]        pgood_in,
  output logic [N_CONN*DW-1:0]   odd_out,
  output logic [N_CONN*DW-1:0]   odd_oe,
  output logic [N_CONN*DW-1:0]   even_out,
  output logic [N_CONN*DW-1:0]   even_oe
);
  localparam int NGRP   = 2 * N_CONN;
  localparam int NSRC   = N_CONN + 1;
  localparam int GW     = DW / 2;
  localparam logic [AW-1:0] PORT_END = AW'(4 * N_CONN);

  logic [DW-1:0]   src_rd [NSRC];
  logic [NGRP-1:0] gnd_q;
  logic            drive_en;

  always_ff @(posedge clk) begin
    if (!rst_n) drive_en <= 1'b0;
    else        drive_en <= 1'b1;
  end

  assign odd_oe  = {(N_CONN*DW){drive_en}};
  assign even_oe = {(N_CONN*DW){drive_en}};

  for (genvar k = 0; k < N_CONN; k++) begin : g_conn
    dio_conn_port #(.W(DW), .IDX(k)) u_port (
      .clk      (clk),
      .rst_n    (rst_n),
      .addr     (bus_addr),
      .rd_en    (bus_rd),
      .wr_en    (bus_wr),
      .wdata    (bus_wdata),
      .in_lo    (conn_in[k*IN_PER +: DW]),
      .in_hi    (conn_in[k*IN_PER + DW +: DW]),
      .gnd      (gnd_q[2*k +: 2]),
      .odd_q    (odd_out[k*DW +: DW]),
      .even_pin (even_out[k*DW +: DW]),
      .rdata    (src_rd[k])
    );
  end

  dio_ctrl_regs #(.NGRP(NGRP), .NP50(N_CONN)) u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .addr  (bus_addr),
    .rd_en (bus_rd),
    .wr_en (bus_wr),
    .wdata (bus_wdata),
    .jmp_a (jmp_a),
    .jmp_b (jmp_b),
    .jmp_c (jmp_c),
    .pin50 (pin50_in),
    .pgood (pgood_in),
    .gnd_q (gnd_q),
    .rdata (src_rd[N_CONN])
  );

  always_comb begin
    bus_rdata = '0;
    for (int s = 0; s < NSRC; s++) bus_rdata |= src_rd[s];
  end

  for (genvar g = 0; g < NGRP; g++) begin : g_gchk
    // R6
    gnd_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gnd_q[g] |-> (even_out[g*GW +: GW] == '0 && (&even_oe[g*GW +: GW])));
  end

  // R10
  rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |-> (bus_rdata == '0));

  // R9
  resv_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && ((bus_addr >= PORT_END && bus_addr < OFF_JMP_A) ||
                bus_addr > OFF_PGOOD)) |-> (bus_rdata == '0));

  // R11
  oe_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((&odd_oe) && (&even_oe)));
endmodule

// File: tb/sim_dio_port_ctrl.sv
module sim_dio_port_ctrl;
  localparam int CLK_P = 10;
  localparam int NVEC  = 23;
  // {wr, addr[4:0], wdata[7:0], expected readback[7:0]}
  localparam logic [21:0] VEC [NVEC] = '{
    {1'b1, 5'h00, 8'h81, 8'h81},  // R2
    {1'b1, 5'h04, 8'h42, 8'h42},  // R2
    {1'b1, 5'h08, 8'hFF, 8'hFF},  // R2
    {1'b0, 5'h01, 8'h00, 8'hA5},  // R3
    {1'b0, 5'h02, 8'h00, 8'hB4},  // R3
    {1'b0, 5'h05, 8'h00, 8'hC3},  // R3
    {1'b0, 5'h06, 8'h00, 8'hD2},  // R3
    {1'b0, 5'h09, 8'h00, 8'hE1},  // R3
    {1'b0, 5'h0A, 8'h00, 8'hF0},  // R3
    {1'b1, 5'h03, 8'h3C, 8'h3C},  // R4
    {1'b1, 5'h07, 8'h99, 8'h99},  // R4
    {1'b1, 5'h0B, 8'h5A, 8'h5A},  // R4
    {1'b1, 5'h1B, 8'hFF, 8'h3F},  // R5
    {1'b0, 5'h18, 8'h00, 8'h5A},  // R7
    {1'b0, 5'h19, 8'h00, 8'h96},  // R7
    {1'b0, 5'h1A, 8'h00, 8'h09},  // R7
    {1'b0, 5'h1C, 8'h00, 8'h05},  // R8
    {1'b0, 5'h1D, 8'h00, 8'h02},  // R8
    {1'b1, 5'h01, 8'h77, 8'hA5},  // R9
    {1'b1, 5'h1E, 8'h77, 8'h00},  // R9
    {1'b1, 5'h0C, 8'h77, 8'h00},  // R9
    {1'b1, 5'h18, 8'h00, 8'h5A},  // R9
    {1'b1, 5'h1B, 8'h00, 8'h00}   // R5
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic        bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [47:0] conn_in = 48'hF0E1_D2C3_B4A5;
  logic [7:0]  jmp_a = 8'h5A, jmp_b = 8'h96;
  logic [3:0]  jmp_c = 4'h9;
  logic [2:0]  pin50_in = 3'b101;
  logic [1:0]  pgood_in = 2'b10;
  logic [23:0] odd_out, odd_oe, even_out, even_oe;

  int checks = 0, fails = 0;
  logic [7:0] rv;

  always #(CLK_P/2) clk = ~clk;

  dio_port_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .conn_in(conn_in), .jmp_a(jmp_a), .jmp_b(jmp_b), .jmp_c(jmp_c),
    .pin50_in(pin50_in), .pgood_in(pgood_in), .odd_out(odd_out),
    .odd_oe(odd_oe), .even_out(even_out), .even_oe(even_oe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  initial begin
    #(CLK_P * 200000);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 / R11: state while reset is held
    chk("R1 odd_out in reset", 32'(odd_out), 32'h0);
    chk("R1 even_out in reset", 32'(even_out), 32'h0);
    chk("R11 oe low in reset", 32'(odd_oe | even_oe), 32'h0);
    rd(5'h00, rv);
    chk("R1 latch read in reset", 32'(rv), 32'h0);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    chk("R11 odd_oe after reset", 32'(odd_oe), 32'hFFFFFF);
    chk("R11 even_oe after reset", 32'(even_oe), 32'hFFFFFF);

    for (int i = 0; i < NVEC; i++) begin
      logic [21:0] v;
      v = VEC[i];
      if (v[21]) wr(v[20:16], v[15:8]);
      rd(v[20:16], rv);
      chk($sformatf("vector %0d addr %h (R2-R9)", i, v[20:16]), 32'(rv), 32'(v[7:0]));
    end

    // R2 / R4 / R9: pins after table, ignored writes left them intact
    chk("R2 odd_out", 32'(odd_out), 32'hFF4281);
    chk("R4 even_out", 32'(even_out), 32'h5A993C);

    // R10: no read strobe
    @(negedge clk) bus_addr = 5'h00; #1;
    chk("R10 rdata idle", 32'(bus_rdata), 32'h0);

    // R3: input change seen in same cycle
    conn_in[15:8] = 8'h1E;
    rd(5'h02, rv);
    chk("R3 live input", 32'(rv), 32'h1E);

    // R5 / R6: conn0 high group and conn1 low group grounded
    wr(5'h1B, 8'h06);
    chk("R6 grounded pins", 32'(even_out), 32'h5A900C);
    chk("R6 oe while grounded", 32'(even_oe), 32'hFFFFFF);
    rd(5'h03, rv);
    chk("R6 latch kept", 32'(rv), 32'h3C);

    // R6: write while grounded, then release
    wr(5'h03, 8'hF7);
    chk("R6 write under ground", 32'(even_out[7:0]), 32'h07);
    rd(5'h03, rv);
    chk("R6 readback under ground", 32'(rv), 32'hF7);
    wr(5'h1B, 8'h00);
    chk("R6 release restores", 32'(even_out), 32'h5A99F7);

    // R5: bit mapping for last connector
    wr(5'h1B, 8'h10);
    chk("R5 bit4 low group", 32'(even_out[23:16]), 32'h50);
    wr(5'h1B, 8'h20);
    chk("R5 bit5 high group", 32'(even_out[23:16]), 32'h0A);
    rd(5'h1B, rv);
    chk("R5 readback", 32'(rv), 32'h20);

    // R1: reset mid-run clears latches and drops enables
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk);
    chk("R1 odd_out cleared", 32'(odd_out), 32'h0);
    chk("R1 even_out cleared", 32'(even_out), 32'h0);
    chk("R11 oe dropped", 32'(even_oe), 32'h0);
    rd(5'h1B, rv);
    chk("R1 ground reg cleared", 32'(rv), 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule